// File: doc/BRIEF.md
# Programmable Down-Counting Timer with APB Access

This block is a 32-bit countdown timer that sits on an APB slave port and signals expiry through a level interrupt. Software programs a start value and a reload value, picks what drives a count step, and enables the interrupt. A count step can come from every cycle of the bus clock. It can also come from that clock but only while an external input is high. A third source is each rising edge of the external input. The external input is brought into the bus clock domain through a two-flop synchronizer.

An interrupt flag is raised only when a count step takes the counter from 1 to 0 while interrupts are enabled. The counter then waits at zero for one count step before it takes the reload value. The programmed period is therefore reload + 1 steps. A reload value of zero parks the counter at zero and produces no more interrupts. The flag is sticky, the interrupt pin follows it, and software clears it by writing a one. A fixed identification bank at the top of the 4 KB window lets software recognise the block.

Top module: `apb_countdown_timer`

## Requirements
- R1: With enable (control bit 0) set and neither external mode selected, the counter value drops by one on every bus clock. With enable clear, the value holds.
- R2: The control register at offset 0x0 keeps bits [3:0] of a write. Bit 0 is enable, bit 1 is external-gate mode, bit 2 is external-clock mode and bit 3 is interrupt enable. Bits [31:4] always read as zero.
- R3: A count step from 1 to 0 sets the interrupt flag only if control bit 3 is set. The next count step keeps the counter at zero for one step, and the step after that loads the reload value, giving an interrupt every reload + 1 steps.
- R4: A write to the reload register (offset 0x8) sets both the reload value and the current counter value.
- R5: A write to the value register (offset 0x4) loads the counter and leaves the reload value unchanged. A register write takes precedence over a count step in the same cycle.
- R6: Bit 0 of the status register (offset 0xC) is a sticky flag. Writing 1 to it clears it and writing 0 has no effect. The irq output always equals this flag.
- R7: While the reload value is 0, a counter at zero stays at zero and no further interrupt is raised.
- R8: Reset clears control, counter, reload and the interrupt flag, so all four registers read 0 and irq is low.
- R9: When a write-one-to-clear of the flag and an interrupt-raising expiry fall in the same cycle, the flag ends up set.
- R10: In external-gate mode (control bit 1), the counter steps only on clocks where the synchronized external input is high. A high pulse lasting N clocks produces exactly N steps.
- R11: In external-clock mode (control bit 2), the counter steps once for each rising edge of the synchronized external input and never on the bus clock alone.
- R12: The twelve word offsets 0xFD0 + 4*i (i = 0..11) return identification byte i from the list 0x4E, 0x00, 0x00, 0x00, 0x31, 0x7A, 0x0B, 0x00, 0x6C, 0x93, 0x15, 0xE2. Writes there are ignored. Any other unmapped or misaligned offset reads 0.
- R13: Every transfer completes without wait states and without error: pready is 1 and pslverr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the default count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address within the 4 KB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, held high |
| pslverr | output | 1 | Transfer error, held low |
| ext_in | input | 1 | Asynchronous external gate or count clock |
| irq | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
The hardest case to reach from the ports is an expiry and a write-one-to-clear landing on the same clock edge while the flag is already set. This is the case where the set must win. The stimulus first loads the counter with 1 so that the flag gets set. It then loads 2 and starts the clear transfer right away. The clear commits on exactly the edge where the counter steps from 1 to 0. Both external modes are driven with pulses of known length, so the expected step count follows directly from the number of clocks or edges. The hold-at-zero step is checked through the gap between two interrupts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W   = 32;
  localparam int ID_COUNT = 12;

  // word offsets of the programmable registers
  localparam logic [9:0] WOFF_CTRL   = 10'h000;
  localparam logic [9:0] WOFF_VALUE  = 10'h001;
  localparam logic [9:0] WOFF_RELOAD = 10'h002;
  localparam logic [9:0] WOFF_STATUS = 10'h003;

  // control register layout, bit 3 down to bit 0
  typedef struct packed {
    logic irq_en;
    logic ext_clk;
    logic ext_gate;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;

  // a detected edge lasts a single cycle
  p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_value,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             ld_any;

  assign ld_any = wr_value | wr_reload;

  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    expire = 1'b0;
    if (wr_reload) begin
      rld_d = wdata;
      cnt_d = wdata;
    end else if (wr_value) begin
      cnt_d = wdata;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
      end else begin
        cnt_d  = cnt_q - ONE;
        expire = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(ld_any) && $past(cnt_q) > ONE) |-> cnt_q == $past(cnt_q) - ONE);

  p_zero_after_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(expire) |-> cnt_q == '0);

  p_reload_after_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(ld_any) && $past(cnt_q) == '0) |-> cnt_q == $past(rld_q));

  p_zero_reload_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && $past(rld_q) == '0 && !$past(ld_any)) |-> (cnt_q == '0 && !expire));

endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
  import tmr_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          ADDR_W      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [95:0] ID_BYTES    = 96'hE215936C_000B7A31_0000004E
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq
);

  localparam int WA_W     = ADDR_W - 2;
  localparam int ID_FIRST = (1 << WA_W) - ID_COUNT;

  ctrl_t            ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic [WA_W-1:0]  waddr;
  logic             aligned, wr_en;
  logic             wr_ctrl, wr_value, wr_reload, wr_status, clr_req;
  logic             ext_lvl, ext_rise, step, expire;
  logic [CNT_W-1:0] cnt, rld;
  logic [7:0]       id_byte;
  logic [ID_COUNT-1:0] id_hit;

  // ---------------- bus decode ----------------
  assign waddr     = paddr[ADDR_W-1:2];
  assign aligned   = (paddr[1:0] == 2'b00);
  assign wr_en     = psel & penable & pwrite & aligned;
  assign wr_ctrl   = wr_en & (waddr == WA_W'(WOFF_CTRL));
  assign wr_value  = wr_en & (waddr == WA_W'(WOFF_VALUE));
  assign wr_reload = wr_en & (waddr == WA_W'(WOFF_RELOAD));
  assign wr_status = wr_en & (waddr == WA_W'(WOFF_STATUS));
  assign clr_req   = wr_status & pwdata[0];
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

  // ---------------- external input ----------------
  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (pclk),
    .rst_n    (presetn),
    .async_in (ext_in),
    .level    (ext_lvl),
    .rise     (ext_rise)
  );

  assign step = ctrl_q.run
              & (ctrl_q.ext_clk  ? ext_rise : 1'b1)
              & (ctrl_q.ext_gate ? ext_lvl  : 1'b1);

  // ---------------- counter ----------------
  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (pclk),
    .rst_n     (presetn),
    .step      (step),
    .wr_value  (wr_value),
    .wr_reload (wr_reload),
    .wdata     (pwdata[CNT_W-1:0]),
    .cnt       (cnt),
    .rld       (rld),
    .expire    (expire)
  );

  // ---------------- control and flag ----------------
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(pwdata[3:0]);
    // expiry set outranks a same-cycle clear
    flag_d = (flag_q & ~clr_req) | (expire & ctrl_q.irq_en);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q;

  // ---------------- read path ----------------
  for (genvar i = 0; i < ID_COUNT; i++) begin : g_id
    assign id_hit[i] = (waddr == WA_W'(ID_FIRST + i));
  end

  always_comb begin
    id_byte = '0;
    for (int i = 0; i < ID_COUNT; i++) begin
      if (id_hit[i]) id_byte = ID_BYTES[8*i +: 8];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && aligned) begin
      if (waddr == WA_W'(WOFF_CTRL))        prdata = DATA_W'(ctrl_q);
      else if (waddr == WA_W'(WOFF_VALUE))  prdata = DATA_W'(cnt);
      else if (waddr == WA_W'(WOFF_RELOAD)) prdata = DATA_W'(rld);
      else if (waddr == WA_W'(WOFF_STATUS)) prdata = DATA_W'(flag_q);
      else                                  prdata = DATA_W'(id_byte);
    end
  end

  // ---------------- checks ----------------
  p_sticky_r6: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(flag_q) && !$past(clr_req)) |-> flag_q);

  p_set_wins_r9: assert property (@(posedge pclk) disable iff (!presetn)
    $past(expire && ctrl_q.irq_en) |-> flag_q);

  p_irq_needs_enable_r3: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(flag_q) |-> $past(ctrl_q.irq_en));

  p_no_step_when_off_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (!$past(ctrl_q.run) && !$past(wr_value) && !$past(wr_reload)) |-> $stable(cnt));

endmodule

// File: tb/tb_apb_countdown_timer.sv
`timescale 1ns/1ps
module tb_apb_countdown_timer;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite, ext_in;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [11:0] a;
    logic [31:0] e;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  localparam logic [7:0] ID_EXP [12] = '{8'h4E, 8'h00, 8'h00, 8'h00, 8'h31, 8'h7A,
                                         8'h0B, 8'h00, 8'h6C, 8'h93, 8'h15, 8'hE2};

  always #10 pclk = ~pclk;

  apb_countdown_timer dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ext_in(ext_in), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: every task starts just after a falling edge
  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.a = a; it.e = e; it.tag = tag;
    exp_q.push_back(it);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    do begin
      @(negedge pclk);
      k++;
    end while (!irq && k < 60);
  endtask

  // monitor: samples the access phase midway before the completing edge
  initial begin
    forever begin
      @(negedge pclk);
      #5;
      if (psel && penable && !pwrite) begin
        exp_t it;
        chk(pready && !pslverr, "R13 ready/error", {30'd0, pready, pslverr}, 32'h2);
        if (exp_q.size() == 0) begin
          chk(1'b0, "scoreboard empty", prdata, 32'h0);
        end else begin
          it = exp_q.pop_front();
          chk(prdata === it.e, $sformatf("%s @%h", it.tag, it.a), prdata, it.e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL watchdog actual=100000 cycles expected=completion earlier");
    finish_run();
  end

  initial begin
    int k;
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; ext_in = 1'b0;
    idle(4);
    presetn = 1'b1;
    idle(1);

    // R8 reset state
    chk(irq === 1'b0, "R8 irq after reset", {31'd0, irq}, 32'd0);
    apb_rd(12'h000, 32'h0, "R8 ctrl");
    apb_rd(12'h004, 32'h0, "R8 value");
    apb_rd(12'h008, 32'h0, "R8 reload");
    apb_rd(12'h00C, 32'h0, "R8 status");

    // R2 only low four control bits stored
    apb_wr(12'h000, 32'hFFFF_FFFA);
    apb_rd(12'h000, 32'h0000_000A, "R2 ctrl mask");
    apb_wr(12'h000, 32'h0);

    // R4 reload write loads counter; R5 value write leaves reload
    apb_wr(12'h008, 32'h0000_1234);
    apb_rd(12'h004, 32'h0000_1234, "R4 value from reload");
    apb_rd(12'h008, 32'h0000_1234, "R4 reload");
    apb_wr(12'h004, 32'h0000_0055);
    apb_rd(12'h004, 32'h0000_0055, "R5 value");
    apb_rd(12'h008, 32'h0000_1234, "R5 reload kept");
    idle(5);
    apb_rd(12'h004, 32'h0000_0055, "R1 holds while disabled");

    // R1 counting on the bus clock; R5 write wins over the step
    apb_wr(12'h000, 32'h1);
    apb_wr(12'h004, 32'd100);
    apb_rd(12'h004, 32'd99, "R1 one step per clock");

    // R3 expiry after reload steps, then period reload+1
    apb_wr(12'h000, 32'h9);
    apb_wr(12'h008, 32'd5);
    wait_irq(k);
    chk(k == 5, "R3 first expiry delay", k, 5);
    apb_wr(12'h00C, 32'h1);
    wait_irq(k);
    chk(k == 4, "R3 hold at zero then reload", k, 4);
    // R6 write of zero leaves the flag
    apb_wr(12'h00C, 32'h0);
    chk(irq === 1'b1, "R6 zero write no effect", {31'd0, irq}, 32'd1);
    apb_wr(12'h00C, 32'h1);
    chk(irq === 1'b0, "R6 one clears", {31'd0, irq}, 32'd0);
    apb_wr(12'h000, 32'h0);
    apb_wr(12'h00C, 32'h1);

    // R3 interrupt enable off: no flag
    apb_wr(12'h000, 32'h1);
    apb_wr(12'h008, 32'd3);
    idle(20);
    chk(irq === 1'b0, "R3 no flag without enable", {31'd0, irq}, 32'd0);
    apb_rd(12'h00C, 32'h0, "R3 status without enable");

    // R7 zero reload parks the counter
    apb_wr(12'h000, 32'h9);
    apb_wr(12'h008, 32'd0);
    idle(20);
    chk(irq === 1'b0, "R7 idle at zero", {31'd0, irq}, 32'd0);
    apb_wr(12'h004, 32'd2);
    idle(3);
    chk(irq === 1'b1, "R3 expiry from value write", {31'd0, irq}, 32'd1);
    apb_rd(12'h00C, 32'h1, "R6 status shows flag");
    apb_wr(12'h00C, 32'h1);
    idle(20);
    chk(irq === 1'b0, "R7 no further interrupt", {31'd0, irq}, 32'd0);
    apb_rd(12'h004, 32'h0, "R7 value stays zero");

    // R9 clear and expiry on the same edge with flag already set
    apb_wr(12'h008, 32'd50);
    apb_wr(12'h004, 32'd1);
    apb_wr(12'h004, 32'd2);
    apb_wr(12'h00C, 32'h1);
    chk(irq === 1'b1, "R9 set wins over clear", {31'd0, irq}, 32'd1);
    apb_wr(12'h000, 32'h0);
    apb_wr(12'h00C, 32'h1);
    chk(irq === 1'b0, "R6 cleared after R9", {31'd0, irq}, 32'd0);

    // R10 external gate
    apb_wr(12'h000, 32'h3);
    apb_wr(12'h004, 32'd50);
    idle(10);
    apb_rd(12'h004, 32'd50, "R10 gate low holds");
    ext_in = 1'b1;
    idle(10);
    ext_in = 1'b0;
    idle(5);
    apb_rd(12'h004, 32'd40, "R10 ten gated steps");

    // R11 external clock
    apb_wr(12'h000, 32'h5);
    apb_wr(12'h004, 32'd50);
    idle(6);
    apb_rd(12'h004, 32'd50, "R11 no step without edge");
    for (int p = 0; p < 7; p++) begin
      ext_in = 1'b1; idle(3);
      ext_in = 1'b0; idle(3);
    end
    idle(5);
    apb_rd(12'h004, 32'd43, "R11 one step per edge");
    apb_wr(12'h000, 32'h0);

    // R12 identification bank
    for (int i = 0; i < 12; i++) begin
      apb_rd(12'hFD0 + 12'(4*i), {24'd0, ID_EXP[i]}, "R12 id byte");
    end
    apb_wr(12'hFD0, 32'hFFFF_FFFF);
    apb_rd(12'hFD0, 32'h4E, "R12 write ignored");
    apb_rd(12'h010, 32'h0, "R12 unmapped");
    apb_rd(12'hF00, 32'h0, "R12 unmapped high");
    apb_rd(12'h006, 32'h0, "R12 misaligned");

    idle(3);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule